// File: doc/BRIEF.md
# Per-Lane Single-Bit Error Injector

This block sits on the transmit side of a multi-lane serial link, between the word producers and the serializers. Each lane carries one parallel word per cycle together with a valid strobe. Every lane passes through a single register stage, so output words and strobes follow their inputs by exactly one clock.

On request the block inverts exactly one bit of one word on one chosen lane. The bit position is drawn from a free-running pseudo-random source. The block does not look at what a word holds: control, data and frame-marker words are equally likely to be hit. A downstream receiver that is aligned should then report the damage as a one-cycle pulse on that lane's checksum, framing or descrambler error flag.

Software or a test sequencer drives a lane index and a one-cycle go pulse. It waits for the done level to return high before it changes the index or sends another pulse. The block captures the index when it accepts go. It then corrupts the next valid word on that lane, and raises done again one cycle after the corrupted word has left.

Top module: `lane_bitflip_injector`

## Requirements
- R1: After a synchronous active-low reset, done is 1, every output valid strobe is 0 and every output word is 0.
- R2: Each lane's output word and valid strobe equal that lane's inputs from the previous cycle, unchanged, whenever no corruption is applied to them.
- R3: A go pulse seen while done is 1 is accepted, and done reads 0 in the following cycle.
- R4: A go pulse seen while done is 0 is ignored: it produces no extra corruption and does not extend the busy period.
- R5: The lane index is captured when go is accepted. Later changes to the index input have no effect on the pending request.
- R6: The corruption lands on the first word after acceptance whose valid strobe is 1 on the captured lane. Words with strobe 0 on that lane, and the word present in the cycle that go is accepted, pass through unchanged.
- R7: Each accepted request inverts exactly one bit, at a position below the word width, in exactly one word on one lane. All other lanes pass through unchanged.
- R8: Word content is ignored: all-zero words, all-one words and arbitrary words are corrupted in the same way.
- R9: Done stays 0 while the corrupted word is on the output and reads 1 in the cycle after.
- R10: A lane index at or above the configured lane count selects lane 0. The index is 4 bits wide, and lane i occupies bits [i*WORD_W +: WORD_W] of the word buses and bit i of the strobe buses.
- R11: The bit position is taken modulo the word width from a 16-bit maximal-length LFSR that is seeded nonzero at reset and advances every cycle, so successive requests hit differing positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_words | input | LANES*WORD_W | Per-lane words entering the block |
| in_valid | input | LANES | Per-lane word-valid strobes |
| inj_lane | input | 4 | Lane to corrupt on the next request |
| inj_go | input | 1 | One-cycle request pulse |
| inj_done | output | 1 | High when a new request may be issued |
| out_words | output | LANES*WORD_W | Per-lane words after the register stage |
| out_valid | output | LANES | Per-lane valid strobes after the register stage |

## Verification
A corrupt arm flag or a wrong captured lane shows up at the port one cycle after the next valid word. Either the XOR of input and output has a popcount other than one, or the flipped bit appears on a lane other than the one that was selected. A stuck request state shows up as done that never returns, which the fixed three-cycle request pattern exposes within four cycles. The sweep covers every 4-bit index value against a five-lane build, so a wrong out-of-range mapping is caught on the first index above four.

// File: rtl/lbf_pkg.sv
// Package: shared types for the per-lane bit-flip injector.
// Assumes: none; holds only the request state encoding.
package lbf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // ready, done high
        ST_ARMED = 2'd1,   // waiting for a valid word on the captured lane
        ST_FLUSH = 2'd2    // corrupted word is on the output
    } inj_state_e;
endpackage

// File: rtl/lbf_lfsr.sv
// Module: free-running Galois LFSR used as the random bit-position source.
// Assumes: TAPS describes a maximal-length polynomial for W and SEED is nonzero.
module lbf_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] rnd
);
    // Advance the register once per clock; load the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd <= SEED;
        else        rnd <= (rnd >> 1) ^ (rnd[0] ? TAPS : '0);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0);  // R11
endmodule

// File: rtl/lbf_ctrl.sv
// Module: go/done handshake, lane capture and bit-position capture.
// Assumes: any_hit is high only while armed and the captured lane has a valid word.
module lbf_ctrl
    import lbf_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int SEL_W  = 4,
    parameter int LANE_W = 4,
    parameter int WORD_W = 67,
    parameter int POS_W  = 7,
    parameter int RND_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SEL_W-1:0]  lane_sel,
    input  logic [RND_W-1:0]  rnd,
    input  logic              any_hit,
    output logic              armed,
    output logic [LANE_W-1:0] lane_q,
    output logic [POS_W-1:0]  pos_q,
    output logic              done
);
    inj_state_e state;
    logic [LANE_W-1:0] lane_map;
    logic              accept;

    // Map an out-of-range index onto lane 0.
    always_comb begin
        if (32'(lane_sel) < LANES) lane_map = LANE_W'(lane_sel);
        else                       lane_map = '0;
    end

    assign accept = (state == ST_IDLE) && go;
    assign armed  = (state == ST_ARMED);
    assign done   = (state == ST_IDLE);

    // Request state sequence: idle, armed, flush, idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (go)      state <= ST_ARMED;
                ST_ARMED: if (any_hit) state <= ST_FLUSH;
                ST_FLUSH:              state <= ST_IDLE;
                default:               state <= ST_IDLE;
            endcase
        end
    end

    // Capture lane and random bit position when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            pos_q  <= '0;
        end else if (accept) begin
            lane_q <= lane_map;
            pos_q  <= POS_W'(32'(rnd) % WORD_W);
        end
    end

    AST_GO_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> !done);  // R3
    AST_BUSY_IGNORES_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !any_hit) |=> armed);  // R4
    AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done) |=> $stable(lane_q));  // R5
    AST_DONE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> done);  // R9
    AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lane_q) < LANES);  // R10
    AST_POS_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos_q) < WORD_W);  // R7
endmodule

// File: rtl/lbf_lane.sv
// Module: one lane's register stage with an optional single-bit inversion.
// Assumes: sel is high only while a request is pending for this lane.
module lbf_lane #(
    parameter int WORD_W = 67,
    parameter int POS_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              valid_in,
    input  logic              sel,
    input  logic [POS_W-1:0]  pos,
    output logic [WORD_W-1:0] word_out,
    output logic              valid_out,
    output logic              hit
);
    logic [WORD_W-1:0] mask;
    logic              live_q;

    assign hit  = sel && valid_in;
    assign mask = hit ? (WORD_W'(1) << pos) : '0;

    // Register the word and strobe, inverting the selected bit on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out  <= '0;
            valid_out <= 1'b0;
        end else begin
            word_out  <= word_in ^ mask;
            valid_out <= valid_in;
        end
    end

    // Mark cycles whose previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ($countones(word_out ^ $past(word_in)) <= 1));  // R7
    AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (valid_out == $past(valid_in)));  // R2
endmodule

// File: rtl/lane_bitflip_injector.sv
// Module: top of the per-lane single-bit error injector.
// Assumes: inj_go is a one-cycle pulse issued only while inj_done is high;
//          lane i uses bits [i*WORD_W +: WORD_W] and strobe bit i.
module lane_bitflip_injector #(
    parameter int LANES  = 16,
    parameter int WORD_W = 67,
    parameter int SEL_W  = 4,
    parameter int RND_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*WORD_W-1:0] in_words,
    input  logic [LANES-1:0]        in_valid,
    input  logic [SEL_W-1:0]        inj_lane,
    input  logic                    inj_go,
    output logic                    inj_done,
    output logic [LANES*WORD_W-1:0] out_words,
    output logic [LANES-1:0]        out_valid
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int POS_W  = $clog2(WORD_W);

    logic [RND_W-1:0]  rnd;
    logic              armed;
    logic [LANE_W-1:0] lane_q;
    logic [POS_W-1:0]  pos_q;
    logic [LANES-1:0]  hit_vec;

    lbf_lfsr #(.W(RND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    lbf_ctrl #(
        .LANES (LANES), .SEL_W (SEL_W), .LANE_W (LANE_W),
        .WORD_W(WORD_W), .POS_W (POS_W), .RND_W (RND_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (inj_go),
        .lane_sel (inj_lane),
        .rnd      (rnd),
        .any_hit  (|hit_vec),
        .armed    (armed),
        .lane_q   (lane_q),
        .pos_q    (pos_q),
        .done     (inj_done)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lbf_lane #(.WORD_W(WORD_W), .POS_W(POS_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_in   (in_words[i*WORD_W +: WORD_W]),
            .valid_in  (in_valid[i]),
            .sel       (armed && (lane_q == LANE_W'(i))),
            .pos       (pos_q),
            .word_out  (out_words[i*WORD_W +: WORD_W]),
            .valid_out (out_valid[i]),
            .hit       (hit_vec[i])
        );
    end

    AST_ONE_LANE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));  // R7
    AST_HIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> !armed);  // R6
endmodule

// File: tb/sim_lane_bitflip_injector.sv
module sim_lane_bitflip_injector;
    localparam int LANES = 5;
    localparam int W     = 67;
    localparam int NREQ  = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES*W-1:0] in_words = '0;
    logic [LANES-1:0]   in_valid = '0;
    logic [3:0]         inj_lane = '0;
    logic               inj_go = 1'b0;
    logic               inj_done;
    logic [LANES*W-1:0] out_words;
    logic [LANES-1:0]   out_valid;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] seen = '0;

    always #5 clk = ~clk;

    lane_bitflip_injector #(.LANES(LANES), .WORD_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_words(in_words), .in_valid(in_valid),
        .inj_lane(inj_lane), .inj_go(inj_go), .inj_done(inj_done),
        .out_words(out_words), .out_valid(out_valid)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LANES*W-1:0] pattern(input int kind);
        logic [LANES*W-1:0] p;
        for (int i = 0; i < LANES; i++) begin
            if (kind == 0)      p[i*W +: W] = '0;
            else if (kind == 1) p[i*W +: W] = '1;
            else                p[i*W +: W] = {$urandom, $urandom, $urandom};
        end
        return p;
    endfunction

    // Compare every lane except 'skip' (use LANES for none).
    task automatic chk_pass(input logic [LANES*W-1:0] exp, input int skip, input string req);
        for (int i = 0; i < LANES; i++)
            if (i != skip)
                chk(out_words[i*W +: W] === exp[i*W +: W], req,
                    out_words[i*W +: W], exp[i*W +: W]);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [LANES*W-1:0] pa, pb, pc, pd;
        in_words = pattern(2);
        in_valid = '1;
        repeat (3) tick();
        rst_n = 1'b1;
        chk(inj_done === 1'b1, "R1 done", W'(inj_done), W'(1));
        chk(out_valid === '0, "R1 valid", W'(out_valid), '0);
        chk_pass('0, LANES, "R1 words");

        for (int k = 0; k < NREQ; k++) begin
            int L, eff, nflip, fpos;
            logic [W-1:0] d;
            L   = k % 16;
            eff = (L < LANES) ? L : 0;
            // Issue go; the word present in this cycle must pass unchanged.
            pa = pattern(k % 3);
            inj_lane = 4'(L); inj_go = 1'b1; in_valid = '1; in_words = pa;
            tick();
            chk(inj_done === 1'b0, "R3 done falls", W'(inj_done), W'(0));
            chk_pass(pa, LANES, "R6 go-cycle word unchanged");
            chk(out_valid === '1, "R2 strobes", W'(out_valid), W'({LANES{1'b1}}));
            // Hold the selected lane invalid, move the index elsewhere.
            pb = pattern(2);
            inj_go = 1'b0; inj_lane = 4'((L + 3) % 16);
            in_valid = '1; in_valid[eff] = 1'b0; in_words = pb;
            tick();
            chk_pass(pb, LANES, "R6 invalid word unchanged");
            chk(out_valid[eff] === 1'b0, "R2 strobe delay", W'(out_valid), '0);
            chk(inj_done === 1'b0, "R9 still busy", W'(inj_done), W'(0));
            // Valid word on the captured lane takes the flip.
            pc = pattern((k + 1) % 3);
            in_valid = '1; in_words = pc;
            tick();
            d = out_words[eff*W +: W] ^ pc[eff*W +: W];
            nflip = $countones(d);
            fpos = -1;
            for (int b = 0; b < W; b++) if (d[b]) fpos = b;
            if (fpos >= 0) seen[fpos] = 1'b1;
            chk(nflip == 1, $sformatf("R7 R8 R10 one bit on lane %0d (index %0d)", eff, L),
                W'(nflip), W'(1));
            chk_pass(pc, eff, "R5 R7 other lanes unchanged");
            chk(inj_done === 1'b0, "R9 low with corrupted word", W'(inj_done), W'(0));
            // A go now is ignored.
            pd = pattern(2);
            inj_go = 1'b1; inj_lane = 4'(L); in_words = pd;
            tick();
            chk(inj_done === 1'b1, "R9 done returns", W'(inj_done), W'(1));
            chk_pass(pd, LANES, "R4 ignored go word");
            inj_go = 1'b0;
            in_words = pattern(1);
            tick();
            chk_pass(pattern(1), LANES, "R4 no late flip");
            chk(inj_done === 1'b1, "R4 stays idle", W'(inj_done), W'(1));
        end
        chk($countones(seen) >= 2, "R11 positions vary", W'($countones(seen)), W'(2));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule